// File: doc/BRIEF.md
# Supervisor Call Exception Entry Unit

This unit sits next to the decode stage of a small 32-bit core and watches each decoded instruction for a request to enter the operating system. It recognises the call form of both instruction sets the core runs: the 32-bit set and the compact 16-bit set. For the 32-bit form it tests the condition code against the current NZCV flags. A call that fails its condition retires as a no-op.

When the call is taken, the unit emits a redirect one cycle later that lasts exactly one cycle. The redirect carries:
- the address of the next instruction, to be written into the supervisor copy of the link register;
- the vector PC;
- the new mode bits;
- the caller's mode, saved for the handler;
- the zero-extended immediate;
- a syndrome word for a hypervisor.

A pipeline flush pulse is raised in the same cycle. An external route input sends the call to the hypervisor instead of the supervisor. The immediate is forwarded only as information and never changes core state.

Top module: `supcall_entry`

## Requirements
- R1: A 32-bit instruction (`compact`=0) is a call when bits 27:24 are 4'b1111. Its condition is bits 31:28 and its immediate is bits 23:0. A 16-bit instruction (`compact`=1) is a call when bits 15:8 are 8'hDF. Its immediate is bits 7:0 zero-extended, and it is always taken. Any other word never raises `redirect`.
- R2: Condition codes are evaluated over flags {N,Z,C,V} = `flags[3:0]`:
  - 0:Z, 1:!Z, 2:C, 3:!C, 4:N, 5:!N, 6:V, 7:!V;
  - 8:C&!Z, 9:!C|Z;
  - 10:N==V, 11:N!=V;
  - 12:!Z&(N==V), 13:Z|(N!=V);
  - 14: always.
- R3: Code 4'b1111 never takes the call. A failed condition, a non-call word, or `instr_valid`=0 leaves every output except `flags_out` at zero in the next cycle.
- R4: One cycle after a taken call, `redirect` and `flush` are both 1 for that single cycle. `ret_addr` is `pc_in`+4 for a 32-bit call and `pc_in`+2 for a 16-bit call.
- R5: On a supervisor entry (`route_hyp`=0), `vec_pc` is VEC_ADDR (default 32'h8) and `mode_out` is 5'b10011. On a hypervisor entry (`route_hyp`=1), `vec_pc` is HVEC_ADDR (default 32'h14) and `mode_out` is 5'b11010.
- R6: `flags_out` equals `flags` from the previous cycle, whether or not a call is taken.
- R7: On a taken call, the syndrome has this layout:
  - bits 31:26 hold the exception class 6'h11;
  - bit 25 is 1 for a 32-bit call;
  - bits 24:16 are zero;
  - bits 15:0 are the low 16 bits of the immediate.
  
  `to_hyp` mirrors `route_hyp` for that call.
- R8: On a taken call, `imm_out` carries the zero-extended immediate and `saved_mode` carries `mode_in`. The immediate has no effect on any other output.
- R9: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Decode slot holds a real instruction |
| instr | input | 32 | Instruction word (16-bit forms in bits 15:0) |
| compact | input | 1 | Core is in 16-bit instruction state |
| pc_in | input | 32 | Address of the instruction |
| flags | input | 4 | Current {N,Z,C,V} |
| mode_in | input | 5 | Current mode bits |
| route_hyp | input | 1 | Send the call to the hypervisor |
| redirect | output | 1 | One-cycle exception entry strobe |
| flush | output | 1 | Pipeline flush pulse |
| ret_addr | output | 32 | Return address for the banked link register |
| vec_pc | output | 32 | New PC |
| mode_out | output | 5 | New mode bits |
| saved_mode | output | 5 | Caller's mode |
| flags_out | output | 4 | Flags, carried through unchanged |
| imm_out | output | 24 | Zero-extended immediate |
| syndrome | output | 32 | Syndrome word |
| to_hyp | output | 1 | Entry goes to the hypervisor |

## Verification
Any decode or condition fault appears at the ports in the cycle right after the instruction:
- a condition-table slip makes `redirect` appear or vanish for exactly one code and flag pattern, which is why every code is swept against several flag sets;
- a wrong return offset or instruction-length bit shows up in `ret_addr` or in syndrome bit 25.

Stuck state would leave `redirect` high for a second cycle or leave the data outputs non-zero after a no-op, so the next idle cycle is checked as well.

// File: rtl/supcall_entry.sv
module supcall_entry #(
  parameter logic [31:0] VEC_ADDR  = 32'h0000_0008,
  parameter logic [31:0] HVEC_ADDR = 32'h0000_0014,
  parameter logic [4:0]  SUP_MODE  = 5'b10011,
  parameter logic [4:0]  HYP_MODE  = 5'b11010,
  parameter logic [5:0]  EXC_CLASS = 6'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [31:0] instr,
  input  logic        compact,
  input  logic [31:0] pc_in,
  input  logic [3:0]  flags,
  input  logic [4:0]  mode_in,
  input  logic        route_hyp,
  output logic        redirect,
  output logic        flush,
  output logic [31:0] ret_addr,
  output logic [31:0] vec_pc,
  output logic [4:0]  mode_out,
  output logic [4:0]  saved_mode,
  output logic [3:0]  flags_out,
  output logic [23:0] imm_out,
  output logic [31:0] syndrome,
  output logic        to_hyp
);

  localparam logic [3:0] COND_AL = 4'b1110;

  logic       n_f, z_f, c_f, v_f;
  logic       wide_hit, short_hit, cond_ok, take;
  logic [3:0] cond;
  logic [23:0] imm;

  assign {n_f, z_f, c_f, v_f} = flags;
  assign wide_hit  = !compact && (instr[27:24] == 4'b1111);
  assign short_hit = compact && (instr[15:8] == 8'hDF);
  assign cond      = compact ? COND_AL : instr[31:28];
  assign imm       = compact ? {16'h0, instr[7:0]} : instr[23:0];

  always_comb begin
    unique case (cond)
      4'h0: cond_ok = z_f;
      4'h1: cond_ok = !z_f;
      4'h2: cond_ok = c_f;
      4'h3: cond_ok = !c_f;
      4'h4: cond_ok = n_f;
      4'h5: cond_ok = !n_f;
      4'h6: cond_ok = v_f;
      4'h7: cond_ok = !v_f;
      4'h8: cond_ok = c_f && !z_f;
      4'h9: cond_ok = !c_f || z_f;
      4'hA: cond_ok = n_f == v_f;
      4'hB: cond_ok = n_f != v_f;
      4'hC: cond_ok = !z_f && (n_f == v_f);
      4'hD: cond_ok = z_f || (n_f != v_f);
      4'hE: cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  assign take = instr_valid && (wide_hit || short_hit) && cond_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect   <= 1'b0;
      flush      <= 1'b0;
      ret_addr   <= '0;
      vec_pc     <= '0;
      mode_out   <= '0;
      saved_mode <= '0;
      flags_out  <= '0;
      imm_out    <= '0;
      syndrome   <= '0;
      to_hyp     <= 1'b0;
    end else begin
      flags_out  <= flags;
      redirect   <= take;
      flush      <= take;
      ret_addr   <= take ? pc_in + (compact ? 32'd2 : 32'd4) : '0;
      vec_pc     <= take ? (route_hyp ? HVEC_ADDR : VEC_ADDR) : '0;
      mode_out   <= take ? (route_hyp ? HYP_MODE : SUP_MODE) : '0;
      saved_mode <= take ? mode_in : '0;
      imm_out    <= take ? imm : '0;
      syndrome   <= take ? {EXC_CLASS, !compact, 9'h0, imm[15:0]} : '0;
      to_hyp     <= take && route_hyp;
    end
  end

  a_r4_ret_offset: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ret_addr == $past(pc_in) + ($past(compact) ? 32'd2 : 32'd4));

  a_r3_idle_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(instr_valid)) |-> !redirect && !flush);

  a_r3_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> (ret_addr == '0 && vec_pc == '0 && syndrome == '0 && imm_out == '0));

  a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> flags_out == $past(flags));

  a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (mode_out == (to_hyp ? HYP_MODE : SUP_MODE)));

  a_r7_class: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> syndrome[31:26] == EXC_CLASS && syndrome[25] == !$past(compact));

endmodule

// File: tb/tb_supcall_entry.sv
module tb_supcall_entry;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        instr_valid = 0;
  logic [31:0] instr = '0;
  logic        compact = 0;
  logic [31:0] pc_in = '0;
  logic [3:0]  flags = '0;
  logic [4:0]  mode_in = '0;
  logic        route_hyp = 0;
  logic        redirect, flush, to_hyp;
  logic [31:0] ret_addr, vec_pc, syndrome;
  logic [4:0]  mode_out, saved_mode;
  logic [3:0]  flags_out;
  logic [23:0] imm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  supcall_entry dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit ref_pass(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    bit r;
    case (c[3:1])
      3'd0: r = z;
      3'd1: r = cy;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = cy & ~z;
      3'd5: r = ~(n ^ v);
      3'd6: r = ~z & ~(n ^ v);
      default: r = 1'b1;
    endcase
    if (c == 4'hF) return 1'b0;
    if (c == 4'hE) return 1'b1;
    return c[0] ? ~r : r;
  endfunction

  task automatic issue(input logic [31:0] w, input logic cmp, input logic [31:0] pc,
                       input logic [3:0] f, input logic [4:0] md, input logic rh);
    @(negedge clk);
    instr_valid = 1; instr = w; compact = cmp; pc_in = pc; flags = f; mode_in = md; route_hyp = rh;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 0; instr = '0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R9 redirect", redirect, 0);
    chk("R9 ret_addr", ret_addr, 0);
    chk("R9 syndrome", syndrome, 0);
    chk("R9 mode_out", mode_out, 0);
    chk("R9 flags_out", flags_out, 0);
  endtask

  task automatic t_wide_always();
    issue(32'hEF00_0010, 0, 32'h0000_1000, 4'h0, 5'b10000, 0);
    chk("R4 redirect", redirect, 1);
    chk("R4 flush", flush, 1);
    chk("R4 ret_addr", ret_addr, 32'h0000_1004);
    chk("R5 vec_pc", vec_pc, 32'h8);
    chk("R5 mode_out", mode_out, 5'b10011);
    chk("R8 saved_mode", saved_mode, 5'b10000);
    chk("R8 imm_out", imm_out, 24'h000010);
    chk("R7 syndrome", syndrome, {6'h11, 1'b1, 9'h0, 16'h0010});
    chk("R7 to_hyp", to_hyp, 0);
    idle();
    chk("R4 single cycle", redirect, 0);
    chk("R3 cleared", ret_addr, 0);
  endtask

  task automatic t_cond_sweep();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f += 5) begin
        issue({c[3:0], 4'hF, 24'h00_0042}, 0, 32'h200, f[3:0], 5'b10000, 0);
        chk($sformatf("R2 cond %0d flags %0d", c, f), redirect, ref_pass(c[3:0], f[3:0]));
      end
    end
    idle();
  endtask

  task automatic t_never();
    issue(32'hFF12_3456, 0, 32'h300, 4'hF, 5'b10000, 0);
    chk("R3 code 15 redirect", redirect, 0);
    chk("R3 code 15 imm", imm_out, 0);
    idle();
  endtask

  task automatic t_compact();
    issue(32'hFFFF_DFAB, 1, 32'h0000_4002, 4'h0, 5'b10000, 0);
    chk("R1 short redirect", redirect, 1);
    chk("R4 short ret_addr", ret_addr, 32'h0000_4004);
    chk("R8 short imm", imm_out, 24'h0000AB);
    chk("R7 short syndrome", syndrome, {6'h11, 1'b0, 9'h0, 16'h00AB});
    idle();
  endtask

  task automatic t_non_calls();
    issue(32'hEE00_0000, 0, 32'h500, 4'h0, 5'b10000, 0);
    chk("R1 wide non-call", redirect, 0);
    issue(32'h0000_DE01, 1, 32'h500, 4'h0, 5'b10000, 0);
    chk("R1 short non-call", redirect, 0);
    issue(32'h0000_DF01, 0, 32'h500, 4'h0, 5'b10000, 0);
    chk("R1 short pattern in wide state", redirect, 0);
    @(negedge clk);
    instr_valid = 0; instr = 32'hEF00_0001; compact = 0;
    @(posedge clk); #1;
    chk("R3 invalid slot", redirect, 0);
    chk("R3 invalid slot vec", vec_pc, 0);
    idle();
  endtask

  task automatic t_hyp();
    issue(32'hEFAB_CDEF, 0, 32'h0000_8000, 4'h0, 5'b10000, 1);
    chk("R5 hyp vec", vec_pc, 32'h14);
    chk("R5 hyp mode", mode_out, 5'b11010);
    chk("R7 to_hyp", to_hyp, 1);
    chk("R7 imm truncated", syndrome, {6'h11, 1'b1, 9'h0, 16'hCDEF});
    chk("R8 full imm", imm_out, 24'hABCDEF);
    idle();
  endtask

  task automatic t_flags();
    issue(32'h0F00_0000, 0, 32'h600, 4'b0100, 5'b10000, 0);
    chk("R6 flags on entry", flags_out, 4'b0100);
    chk("R6 entry taken", redirect, 1);
    @(negedge clk);
    instr_valid = 0; flags = 4'b1011;
    @(posedge clk); #1;
    chk("R6 flags idle", flags_out, 4'b1011);
  endtask

  task automatic t_back_to_back();
    issue(32'hEF00_0001, 0, 32'h700, 4'h0, 5'b10000, 0);
    chk("R4 b2b first", ret_addr, 32'h704);
    issue(32'hEF00_0002, 0, 32'h704, 4'h0, 5'b10000, 0);
    chk("R4 b2b second redirect", redirect, 1);
    chk("R4 b2b second ret", ret_addr, 32'h708);
    chk("R8 b2b imm", imm_out, 24'h2);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_wide_always();
    t_cond_sweep();
    t_never();
    t_compact();
    t_non_calls();
    t_hyp();
    t_flags();
    t_back_to_back();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule